// File: doc/BRIEF.md
# Periodic Radio Timeslot Scheduler

This block opens a recurring window of radio access, measured against a free-running microsecond time base. Software sets three values through a small register bus: an absolute start time, a repeat interval and a slot length. It then arms the scheduler through a trigger register. Once armed, the window opens when the time base reaches the start time. It stays open for the slot length and opens again one interval after each previous opening.

The block also guards the configuration word of a protected ranging engine. A write to that word is accepted only while no window is open. A write made while a window is open is dropped, and it sets a sticky error flag that software clears through the status register. The time base advances on a one-microsecond strobe, `tick_i`, so the block itself runs on any faster clock.

Top module: `slot_sched`

## Requirements
- R1: After reset, `slot_active_o`, `slot_start_o`, `slot_end_o`, `cfg_lock_o` and `cfg_err_o` are 0. `eng_cfg_o` and the start, interval and length registers are 0. The time base is 0 and the scheduler is not armed.
- R2: Register offsets on `reg_addr_i` are 0 = start time, 1 = interval and 2 = length. Each is TIME_W bits wide, taken from the low bits of `reg_wdata_i` on a write, and read back zero-extended on `reg_rdata_o`. Offset 4 (trigger) reads as 0.
- R3: No window opens before a write to offset 4 with data bit 0 set. A trigger write with bit 0 clear is ignored, and so is a trigger write while already armed.
- R4: The time base is a TIME_W-bit counter that adds one on every cycle with `tick_i` high and wraps modulo 2^TIME_W. The next start counts as reached when (time − start) modulo 2^TIME_W has its top bit clear. A window therefore opens on the tick that brings the time to the start value, or on the first tick after arming if the start lies less than half the range in the past.
- R5: An open window lasts exactly the effective length in ticks. When a start is reached, the next start becomes that start plus the interval. Interval and length are sampled at each start, so a register change affects only later windows.
- R6: The effective length is min(length, interval − 1), and it is 0 when the interval is 0. With an effective length of 0 no window opens, but the next start still advances.
- R7: `slot_start_o` is a one-cycle pulse in the first cycle that `slot_active_o` is high. `slot_end_o` is a one-cycle pulse in the first cycle that it is low again. The two never coincide.
- R8: The status register at offset 3 reads bit 0 = armed, bit 1 = window open and bit 2 = error flag. All other bits read 0.
- R9: `cfg_lock_o` equals `slot_active_o`. An `eng_we_i` in a cycle with no window open loads `eng_wdata_i` into `eng_cfg_o` at the next edge.
- R10: An `eng_we_i` in a cycle with a window open leaves `eng_cfg_o` unchanged and sets `cfg_err_o` at the next edge.
- R11: `cfg_err_o` stays set until a write to offset 3 with data bit 2 set clears it. Writing 0 to that bit has no effect. When a clear and a rejected engine write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-microsecond time-base strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| eng_we_i | input | 1 | Ranging engine configuration write |
| eng_wdata_i | input | CFG_W | Engine configuration data |
| eng_cfg_o | output | CFG_W | Accepted engine configuration |
| slot_active_o | output | 1 | Window open |
| slot_start_o | output | 1 | Window opening pulse |
| slot_end_o | output | 1 | Window closing pulse |
| cfg_lock_o | output | 1 | Engine configuration locked |
| cfg_err_o | output | 1 | Sticky rejected-write flag |

## Verification
Two collisions matter most. The first is an engine configuration write in the very cycle a window opens or closes. The rule is that the decision follows the lock state before the edge. The second is a status clear landing together with a rejected engine write, where the set must win. The bench drives long random runs with a dense tick strobe, frequent engine writes and frequent status clears, using short intervals so that window edges happen every few cycles. Every cycle, it compares the outputs against a model that resolves both collisions in that order. The bench also shrinks the time base to 12 bits so that start times wrap many times during the run.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_START = 3'd0;
  localparam logic [ADDR_W-1:0] A_IVL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LEN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd4;
  localparam int unsigned ST_ARMED  = 0;
  localparam int unsigned ST_ACTIVE = 1;
  localparam int unsigned ST_ERR    = 2;
  typedef enum logic [1:0] {S_OFF, S_WAIT, S_ON} win_state_e;
endpackage

// File: rtl/slot_timebase.sv
module slot_timebase #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [TIME_W-1:0] now_o,
  output logic [TIME_W-1:0] nxt_o
);
  logic [TIME_W-1:0] now_q;

  assign now_o = now_q;
  assign nxt_o = now_q + TIME_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     now_q <= '0;
    else if (tick_i) now_q <= nxt_o;
  end
endmodule

// File: rtl/slot_window.sv
module slot_window
  import slot_sched_pkg::*;
#(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] nxt_time_i,
  input  logic              arm_i,
  input  logic [TIME_W-1:0] start_i,
  input  logic [TIME_W-1:0] ivl_i,
  input  logic [TIME_W-1:0] len_i,
  output logic              armed_o,
  output logic              active_o,
  output logic              start_o,
  output logic              end_o
);
  win_state_e        state_q;
  logic [TIME_W-1:0] next_q, rem_q, eff_len, diff;
  logic              reached;

  // clamp keeps at least one idle tick between windows
  always_comb begin
    if (ivl_i == '0)        eff_len = '0;
    else if (len_i >= ivl_i) eff_len = ivl_i - TIME_W'(1);
    else                    eff_len = len_i;
  end

  // lookahead on the time value this tick produces; sign bit = not yet reached
  assign diff    = nxt_time_i - next_q;
  assign reached = ~diff[TIME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      next_q  <= '0;
      rem_q   <= '0;
      start_o <= 1'b0;
      end_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      end_o   <= 1'b0;
      unique case (state_q)
        S_OFF: if (arm_i) begin
          state_q <= S_WAIT;
          next_q  <= start_i;
        end
        S_WAIT: if (tick_i && reached) begin
          next_q <= next_q + ivl_i;
          if (eff_len != '0) begin
            state_q <= S_ON;
            rem_q   <= eff_len;
            start_o <= 1'b1;
          end
        end
        S_ON: if (tick_i) begin
          rem_q <= rem_q - TIME_W'(1);
          if (rem_q == TIME_W'(1)) begin
            state_q <= S_WAIT;
            end_o   <= 1'b1;
          end
        end
        default: state_q <= S_OFF;
      endcase
    end
  end

  assign armed_o  = (state_q != S_OFF);
  assign active_o = (state_q == S_ON);
endmodule

// File: rtl/slot_cfg_guard.sv
module slot_cfg_guard #(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      err_o <= 1'b0;
    end else begin
      if (we_i && !lock_i) cfg_o <= wdata_i;
      if (we_i && lock_i)  err_o <= 1'b1;
      else if (clr_i)      err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              eng_we_i,
  input  logic [CFG_W-1:0]  eng_wdata_i,
  output logic [CFG_W-1:0]  eng_cfg_o,
  output logic              slot_active_o,
  output logic              slot_start_o,
  output logic              slot_end_o,
  output logic              cfg_lock_o,
  output logic              cfg_err_o
);
  logic [TIME_W-1:0] start_q, ivl_q, len_q, now, nxt;
  logic              armed, arm, clr;

  assign arm = reg_we_i && (reg_addr_i == A_TRIG) && reg_wdata_i[0];
  assign clr = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[ST_ERR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      ivl_q   <= '0;
      len_q   <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        A_START: start_q <= reg_wdata_i[TIME_W-1:0];
        A_IVL:   ivl_q   <= reg_wdata_i[TIME_W-1:0];
        A_LEN:   len_q   <= reg_wdata_i[TIME_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_START: reg_rdata_o[TIME_W-1:0] = start_q;
      A_IVL:   reg_rdata_o[TIME_W-1:0] = ivl_q;
      A_LEN:   reg_rdata_o[TIME_W-1:0] = len_q;
      A_STAT: begin
        reg_rdata_o[ST_ARMED]  = armed;
        reg_rdata_o[ST_ACTIVE] = slot_active_o;
        reg_rdata_o[ST_ERR]    = cfg_err_o;
      end
      default: ;
    endcase
  end

  slot_timebase #(.TIME_W(TIME_W)) i_timebase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .now_o (now),
    .nxt_o (nxt)
  );

  slot_window #(.TIME_W(TIME_W)) i_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .nxt_time_i(nxt),
    .arm_i     (arm),
    .start_i   (start_q),
    .ivl_i     (ivl_q),
    .len_i     (len_q),
    .armed_o   (armed),
    .active_o  (slot_active_o),
    .start_o   (slot_start_o),
    .end_o     (slot_end_o)
  );

  assign cfg_lock_o = slot_active_o;

  slot_cfg_guard #(.CFG_W(CFG_W)) i_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (slot_active_o),
    .we_i   (eng_we_i),
    .wdata_i(eng_wdata_i),
    .clr_i  (clr),
    .cfg_o  (eng_cfg_o),
    .err_o  (cfg_err_o)
  );

  logic unused_now;
  assign unused_now = ^now;
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk
  import slot_sched_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              eng_we_i,
  input logic [CFG_W-1:0]  eng_wdata_i,
  input logic [CFG_W-1:0]  eng_cfg_o,
  input logic              slot_active_o,
  input logic              slot_start_o,
  input logic              slot_end_o,
  input logic              cfg_lock_o,
  input logic              cfg_err_o
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[ST_ERR];

  p_window_moves_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(slot_active_o));
  p_rise_has_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slot_active_o) |-> slot_start_o);
  p_start_in_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |-> slot_active_o && !slot_end_o);
  p_fall_has_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slot_active_o) |-> slot_end_o);
  p_end_outside_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_end_o |-> !slot_active_o);
  p_start_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |=> !slot_start_o);
  p_idle_write_loads_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_i && !cfg_lock_o |=> eng_cfg_o == $past(eng_wdata_i));
  p_busy_write_dropped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we_i && cfg_lock_o |=> $stable(eng_cfg_o) && cfg_err_o);
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && !clr_wr |=> cfg_err_o);
endmodule

bind slot_sched slot_sched_chk #(.DATA_W(DATA_W), .CFG_W(CFG_W)) i_chk (.*);

// File: tb/test_slot_sched.sv
`timescale 1ns/1ps
module test_slot_sched;
  localparam int TW = 12;
  localparam int DW = 32;
  localparam int CW = 32;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          tick_i = 1'b0, reg_we_i = 1'b0, eng_we_i = 1'b0;
  logic [2:0]    reg_addr_i = 3'd3;
  logic [DW-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic [CW-1:0] eng_wdata_i = '0, eng_cfg_o;
  logic          slot_active_o, slot_start_o, slot_end_o, cfg_lock_o, cfg_err_o;

  always #2 clk_i = ~clk_i;

  slot_sched #(.TIME_W(TW), .DATA_W(DW), .CFG_W(CW)) i_slot_sched (.*);

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [TW-1:0] m_now = '0, m_next = '0, m_rem = '0, m_sr = '0, m_ivl = '0, m_len = '0;
  logic          m_armed = 0, m_active = 0, m_sp = 0, m_ep = 0, m_err = 0;
  logic [CW-1:0] m_cfg = '0;

  function automatic logic [TW-1:0] eff(input logic [TW-1:0] ivl, input logic [TW-1:0] len);
    if (ivl == 0) return '0;
    return (len >= ivl) ? ivl - 1'b1 : len;
  endfunction

  function automatic logic [DW-1:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_sr);
      3'd1: return DW'(m_ivl);
      3'd2: return DW'(m_len);
      3'd3: return DW'({m_err, m_active, m_armed});
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input logic t, input logic we, input logic [2:0] a,
                       input logic [DW-1:0] wd, input logic ewe, input logic [CW-1:0] ed);
    logic [TW-1:0] d, e;
    if (ewe && !m_active) m_cfg = ed;
    if (ewe && m_active) m_err = 1'b1;
    else if (we && a == 3'd3 && wd[2]) m_err = 1'b0;
    m_sp = 0; m_ep = 0;
    if (!m_armed) begin
      if (we && a == 3'd4 && wd[0]) begin m_armed = 1; m_next = m_sr; end
    end else if (t) begin
      if (m_active) begin
        m_rem = m_rem - 1'b1;
        if (m_rem == 0) begin m_active = 0; m_ep = 1; end
      end else begin
        d = (m_now + 1'b1) - m_next;
        if (!d[TW-1]) begin
          e = eff(m_ivl, m_len);
          m_next = m_next + m_ivl;
          if (e != 0) begin m_active = 1; m_rem = e; m_sp = 1; end
        end
      end
    end
    if (t) m_now = m_now + 1'b1;
    if (we) case (a)
      3'd0: m_sr  = wd[TW-1:0];
      3'd1: m_ivl = wd[TW-1:0];
      3'd2: m_len = wd[TW-1:0];
      default: ;
    endcase
  endtask

  task automatic cyc(input logic t, input logic we, input logic [2:0] a,
                     input logic [DW-1:0] wd, input logic ewe, input logic [CW-1:0] ed);
    tick_i = t; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    eng_we_i = ewe; eng_wdata_i = ed;
    @(posedge clk_i);
    model(t, we, a, wd, ewe, ed);
    @(negedge clk_i);
    chk("R5 window", DW'(slot_active_o), DW'(m_active));
    chk("R7 start pulse", DW'(slot_start_o), DW'(m_sp));
    chk("R7 end pulse", DW'(slot_end_o), DW'(m_ep));
    chk("R9 lock", DW'(cfg_lock_o), DW'(m_active));
    chk("R10 engine cfg", DW'(eng_cfg_o), DW'(m_cfg));
    chk("R11 err flag", DW'(cfg_err_o), DW'(m_err));
    chk("R2 R8 read data", reg_rdata_o, exp_rd(a));
  endtask

  task automatic idle(input logic t); cyc(t, 0, 3'd3, '0, 0, '0); endtask
  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d); cyc(0, 1, a, d, 0, '0); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int len_cnt;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk("R1 active", DW'(slot_active_o), 0);
    chk("R1 start", DW'(slot_start_o), 0);
    chk("R1 end", DW'(slot_end_o), 0);
    chk("R1 err", DW'(cfg_err_o), 0);
    chk("R1 cfg", DW'(eng_cfg_o), 0);
    chk("R1 status", reg_rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: registers and R3: no window before trigger
    wr(3'd0, 32'hFFFF_F003); wr(3'd1, 32'd10); wr(3'd2, 32'd4);
    cyc(0, 0, 3'd0, '0, 0, '0);
    chk("R2 start trunc", reg_rdata_o, 32'h003);
    wr(3'd4, 32'h2);                 // bit 0 clear: ignored
    for (int i = 0; i < 30; i++) idle(1'b1);
    chk("R3 no window before trigger", DW'(slot_active_o), 0);
    chk("R3 not armed", reg_rdata_o, 0);

    // R4: start in the past -> opens on first tick after arming
    wr(3'd4, 32'h1);
    idle(1'b1);
    chk("R4 past start opens", DW'(slot_active_o), 1);
    for (int i = 0; i < 40; i++) idle(1'b1);
    wr(3'd0, 32'd900); wr(3'd4, 32'h1); // R3: re-trigger while armed ignored
    for (int i = 0; i < 40; i++) idle(1'b1);

    // R6: clamp length to interval-1
    wr(3'd2, 32'd15);
    len_cnt = 0;
    for (int i = 0; i < 12; i++) idle(1'b1);
    for (int i = 0; i < 40 && !slot_start_o; i++) idle(1'b1);
    while (slot_active_o && len_cnt < 50) begin len_cnt++; idle(1'b1); end
    chk("R6 clamped window length", DW'(len_cnt), 9);

    // R10/R11 directed: rejected write with clear in same cycle
    for (int i = 0; i < 40 && !slot_active_o; i++) idle(1'b1);
    cyc(0, 1, 3'd3, 32'h4, 1, 32'hDEAD_BEEF);
    chk("R11 set wins over clear", DW'(cfg_err_o), 1);
    chk("R10 dropped write", eng_cfg_o, m_cfg);
    wr(3'd3, 32'h0);
    chk("R11 zero write keeps flag", DW'(cfg_err_o), 1);
    wr(3'd3, 32'h4);
    chk("R11 clear", DW'(cfg_err_o), 0);

    // R6: interval zero never opens
    wr(3'd1, 32'd0);
    for (int i = 0; i < 30; i++) idle(1'b1);
    chk("R6 zero interval", DW'(slot_active_o), 0);

    // random mix; 12-bit time base wraps several times (R4 R5)
    wr(3'd1, 32'd7); wr(3'd2, 32'd3);
    for (int i = 0; i < 20000; i++) begin
      int r;
      logic t, we, ewe;
      logic [2:0] a;
      logic [DW-1:0] wd;
      r   = int'($urandom_range(0, 99));
      t   = ($urandom_range(0, 3) != 0);
      ewe = ($urandom_range(0, 5) == 0);
      we  = (r < 8);
      a   = 3'd3;
      wd  = '0;
      if (r < 2)      begin a = 3'd1; wd = DW'($urandom_range(0, 40)); end
      else if (r < 4) begin a = 3'd2; wd = DW'($urandom_range(0, 45)); end
      else if (r < 8) begin a = 3'd3; wd = DW'($urandom_range(0, 7)); end
      else if (r < 20) a = 3'($urandom_range(0, 4));
      cyc(t, we, a, wd, ewe, $urandom);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule